// File: doc/BRIEF.md
# Nonvolatile Byte Store Access Controller

This block sits between a small processor's register bus and a 64-byte on-chip nonvolatile data store. Software sees three registers: a location register that picks one of the 64 bytes, a data register that holds the byte to store or the byte last fetched, and a control register. The control register carries four bits: a fetch request, a program request, an arming bit and an enable for the ready interrupt.

Stray programming is guarded against by a two-step sequence. Software first sets the arming bit, which clears itself in hardware after a short window. A program request is accepted only while that bit still reads as set. An accepted program request copies the location and the byte into private holding registers. The controller then counts a programming interval on its own, and the program bit stays set until the cell is updated. While the program bit is clear and both interrupt enables are set, the ready interrupt is held high. Each accepted access also raises a stall request toward the processor for two clock cycles.

The cell array is modelled as a synchronous RAM. A programming interval counted in clock cycles stands in for the real programming time. The interval is a parameter, so a bench can shorten it.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset the control register reads 0, the data register reads 0, `irq_o` is 0 and `stall_o` is 0. The location register has no defined reset value.
- R2: A write with `bus_sel`=0 loads the low 6 bits of `bus_wdata` into the location register. Reading with `bus_sel`=0 returns those 6 bits zero-extended, and locations 0 to 63 are distinct bytes. `bus_sel`=1 selects the data register and `bus_sel`=2 the control register. Control bits: bit0 fetch, bit1 program, bit2 arm, bit3 ready-interrupt enable.
- R3: A control write with bit0=1, made while no access is under way, starts a fetch. Bit0 reads 1 for two cycles after that write. In the cycle it first reads 0 again, the data register holds the byte stored at the location register's address.
- R4: A control write with bit1=1 starts programming only if bit2 reads 1 in the cycle of that write. Setting bit1 and bit2 in the same write, or setting bit1 while bit2 reads 0, starts nothing.
- R5: Writing bit2=1 makes bit2 read 1 for exactly 4 cycles, after which hardware clears it. Writing bit2=0 does not end the window. A program request made in the first cycle after the window has expired is rejected. A request made in the last armed cycle is accepted. An accepted program request also clears bit2.
- R6: After an accepted program request, bit1 reads 1 for exactly PROG_CYCLES cycles. The addressed byte holds the new value once bit1 has cleared.
- R7: `irq_o` is 1 exactly when bit3 is 1, `gie_i` is 1 and bit1 reads 0. This is a level signal, not a pulse.
- R8: `stall_o` is 1 for exactly the two cycles after each accepted fetch or program request. It stays 0 after a rejected request.
- R9: While a fetch or a programming interval is under way, new fetch and program requests are ignored.
- R10: Writes to the location or data register during programming do not change which byte is programmed or the value stored there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select: 0 location, 1 data, 2 control |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Read data of the selected register (combinational) |
| gie_i | input | 1 | Global interrupt enable from the processor |
| irq_o | output | 1 | Ready interrupt (level) |
| stall_o | output | 1 | Processor stall request |

## Verification
The assertions check several rules on every cycle:
- The arming window never lasts longer than its set length.
- Programming never begins unless the arming bit was set in the cycle before.
- The programming interval and the stall never exceed their lengths.
- Every programming start brings a stall with it.
- A fetch and a programming interval never overlap.
- The interrupt is low throughout programming.

Only the bench's scenarios can show the rest:
- The exact cycle at which a request is rejected because the window has expired.
- The bytes that come back from particular locations after overwrites and after writes to the location and data registers during programming.
- The value that the location register reads back.

// File: rtl/nvm_ctrl_pkg.sv
package nvm_ctrl_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // bit3 ready-irq enable, bit2 arm, bit1 program, bit0 fetch
    typedef struct packed {
        logic rdy_ie;
        logic arm;
        logic prog;
        logic fetch;
    } ctrl_bits_t;

    localparam int CTRL_W = $bits(ctrl_bits_t);

    function automatic ctrl_bits_t decode_ctrl(input logic [CTRL_W-1:0] raw);
        return ctrl_bits_t'(raw);
    endfunction

endpackage

// File: rtl/nvm_down_timer.sv
module nvm_down_timer #(
    parameter int CYCLES = 4,
    parameter int CW     = $clog2(CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          clear,
    output logic [CW-1:0] count_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o <= '0;
        end else if (clear) begin
            count_o <= '0;
        end else if (load) begin
            count_o <= CW'(CYCLES);
        end else if (count_o != '0) begin
            count_o <= count_o - 1'b1;
        end
    end

endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        if (re) begin
            rdata <= cells[raddr];
        end
    end

endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
    import nvm_ctrl_pkg::*;
#(
    parameter int DEPTH        = 64,
    parameter int DATA_W       = 8,
    parameter int PROG_CYCLES  = 37000,
    parameter int ARM_CYCLES   = 4,
    parameter int STALL_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              gie_i,
    output logic              irq_o,
    output logic              stall_o
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PW     = $clog2(PROG_CYCLES + 1);
    localparam int AW     = $clog2(ARM_CYCLES + 1);
    localparam int SW     = $clog2(STALL_CYCLES + 1);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] hold_addr_q;
    logic [DATA_W-1:0] hold_data_q;
    logic              rdy_ie_q;
    logic              fetch_q;
    logic              capture_q;
    logic [DATA_W-1:0] cell_rdata;

    logic [PW-1:0] prog_cnt;
    logic [AW-1:0] arm_cnt;
    logic [SW-1:0] stall_cnt;

    logic       ctrl_wr;
    ctrl_bits_t req;
    ctrl_bits_t ctrl_view;
    logic       armed;
    logic       prog_busy;
    logic       prog_last;
    logic       rd_busy;
    logic       idle;
    logic       start_prog;
    logic       start_fetch;

    assign ctrl_wr     = bus_wr && (reg_sel_e'(bus_sel) == SEL_CTRL);
    assign req         = decode_ctrl(bus_wdata[CTRL_W-1:0]);
    assign armed       = (arm_cnt != '0);
    assign prog_busy   = (prog_cnt != '0);
    assign prog_last   = (prog_cnt == PW'(1));
    assign rd_busy     = fetch_q || capture_q;
    assign idle        = !prog_busy && !rd_busy;
    assign start_prog  = ctrl_wr && req.prog && armed && idle;
    assign start_fetch = ctrl_wr && req.fetch && idle && !start_prog;

    nvm_down_timer #(.CYCLES(ARM_CYCLES)) arm_tmr_i (
        .clk     (clk),
        .rst     (rst),
        .load    (ctrl_wr && req.arm),
        .clear   (start_prog),
        .count_o (arm_cnt)
    );

    nvm_down_timer #(.CYCLES(PROG_CYCLES)) prog_tmr_i (
        .clk     (clk),
        .rst     (rst),
        .load    (start_prog),
        .clear   (1'b0),
        .count_o (prog_cnt)
    );

    nvm_down_timer #(.CYCLES(STALL_CYCLES)) stall_tmr_i (
        .clk     (clk),
        .rst     (rst),
        .load    (start_prog || start_fetch),
        .clear   (1'b0),
        .count_o (stall_cnt)
    );

    nvm_cell_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) cells_i (
        .clk   (clk),
        .we    (prog_last),
        .waddr (hold_addr_q),
        .wdata (hold_data_q),
        .re    (fetch_q),
        .raddr (addr_q),
        .rdata (cell_rdata)
    );

    // location register: no reset, software loads it before use
    always_ff @(posedge clk) begin
        if (bus_wr && reg_sel_e'(bus_sel) == SEL_ADDR) begin
            addr_q <= bus_wdata[ADDR_W-1:0];
        end
        if (start_prog) begin
            hold_addr_q <= addr_q;
            hold_data_q <= data_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q    <= '0;
            rdy_ie_q  <= 1'b0;
            fetch_q   <= 1'b0;
            capture_q <= 1'b0;
        end else begin
            fetch_q   <= start_fetch;
            capture_q <= fetch_q;
            if (capture_q) begin
                data_q <= cell_rdata;
            end else if (bus_wr && reg_sel_e'(bus_sel) == SEL_DATA) begin
                data_q <= bus_wdata;
            end
            if (ctrl_wr) begin
                rdy_ie_q <= req.rdy_ie;
            end
        end
    end

    always_comb begin
        ctrl_view.rdy_ie = rdy_ie_q;
        ctrl_view.arm    = armed;
        ctrl_view.prog   = prog_busy;
        ctrl_view.fetch  = rd_busy;
        bus_rdata        = '0;
        unique case (reg_sel_e'(bus_sel))
            SEL_ADDR: bus_rdata[ADDR_W-1:0] = addr_q;
            SEL_DATA: bus_rdata             = data_q;
            SEL_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_view;
            default:  bus_rdata             = '0;
        endcase
    end

    assign irq_o   = rdy_ie_q && gie_i && !prog_busy;
    assign stall_o = (stall_cnt != '0);

endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk #(
    parameter int PROG_CYCLES  = 37000,
    parameter int ARM_CYCLES   = 4,
    parameter int STALL_CYCLES = 2
) (
    input logic clk,
    input logic rst,
    input logic armed,
    input logic prog_busy,
    input logic rd_busy,
    input logic stall_o,
    input logic irq_o
);

    localparam int PCW = $clog2(PROG_CYCLES + 2);
    localparam int ACW = $clog2(ARM_CYCLES + 2);
    localparam int SCW = $clog2(STALL_CYCLES + 2);

    logic [PCW-1:0] prog_run;
    logic [ACW-1:0] arm_run;
    logic [SCW-1:0] stall_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_run  <= '0;
            arm_run   <= '0;
            stall_run <= '0;
        end else begin
            prog_run  <= prog_busy ? ((prog_run == '1) ? prog_run : prog_run + 1'b1) : '0;
            arm_run   <= armed ? ((arm_run == '1) ? arm_run : arm_run + 1'b1) : '0;
            stall_run <= stall_o ? ((stall_run == '1) ? stall_run : stall_run + 1'b1) : '0;
        end
    end

    AST_ARM_WINDOW_LEN: assert property (@(posedge clk) disable iff (rst)
        arm_run <= ACW'(ARM_CYCLES)); // R5
    AST_PROG_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_busy) |-> $past(armed)); // R4
    AST_PROG_LEN: assert property (@(posedge clk) disable iff (rst)
        prog_run <= PCW'(PROG_CYCLES)); // R6
    AST_IRQ_QUIET_BUSY: assert property (@(posedge clk) disable iff (rst)
        prog_busy |-> !irq_o); // R7
    AST_STALL_ON_PROG: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_busy) |-> stall_o); // R8
    AST_STALL_LEN: assert property (@(posedge clk) disable iff (rst)
        stall_run <= SCW'(STALL_CYCLES)); // R8
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(rd_busy && prog_busy)); // R9

endmodule

bind nvm_ctrl nvm_ctrl_chk #(
    .PROG_CYCLES  (PROG_CYCLES),
    .ARM_CYCLES   (ARM_CYCLES),
    .STALL_CYCLES (STALL_CYCLES)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .armed     (armed),
    .prog_busy (prog_busy),
    .rd_busy   (rd_busy),
    .stall_o   (stall_o),
    .irq_o     (irq_o)
);

// File: tb/nvm_ctrl_tb_top.sv
module nvm_ctrl_tb_top;

    localparam int  PROG = 20;
    localparam time CLK_P = 8ns;

    typedef struct packed {
        logic [7:0] addr_byte;
        logic [7:0] data;
        logic [5:0] exp_addr;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'h00, 8'hA5, 6'd0},
        '{8'h3F, 8'h5A, 6'd63},
        '{8'hC7, 8'h3C, 6'd7},
        '{8'h15, 8'hFF, 6'd21},
        '{8'h07, 8'h00, 6'd7},
        '{8'h2A, 8'h81, 6'd42}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       gie_i = 1'b0;
    logic       irq_o;
    logic       stall_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    nvm_ctrl #(.PROG_CYCLES(PROG)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .gie_i     (gie_i),
        .irq_o     (irq_o),
        .stall_o   (stall_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic peek(input logic [1:0] sel, output logic [7:0] v);
        bus_sel = sel;
        #1;
        v = bus_rdata;
    endtask

    task automatic bus_write(input logic [1:0] sel, input logic [7:0] d);
        bus_sel   = sel;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] c;
        int guard = 0;
        peek(2'd2, c);
        while (c[1] && guard < 10 * PROG) begin
            step();
            peek(2'd2, c);
            guard++;
        end
    endtask

    task automatic prog_byte(input logic [7:0] a, input logic [7:0] d, input logic [7:0] ie);
        bus_write(2'd0, a);
        bus_write(2'd1, d);
        bus_write(2'd2, 8'h04 | ie);
        bus_write(2'd2, 8'h02 | ie);
    endtask

    task automatic fetch_byte(input logic [7:0] a, output logic [7:0] v);
        logic [7:0] c;
        bus_write(2'd0, a);
        bus_write(2'd2, 8'h01);
        peek(2'd2, c);
        check(c[0] == 1'b1, "R3 fetch bit cycle1", int'(c[0]), 1);
        step();
        peek(2'd2, c);
        check(c[0] == 1'b1, "R3 fetch bit cycle2", int'(c[0]), 1);
        step();
        peek(2'd2, c);
        check(c[0] == 1'b0, "R3 fetch bit cleared", int'(c[0]), 0);
        peek(2'd1, v);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] c;
        int n;

        repeat (3) step();
        rst = 1'b0;
        gie_i = 1'b1;
        step();

        // R1 reset state
        peek(2'd2, v);
        check(v == 8'h00, "R1 control after reset", v, 0);
        peek(2'd1, v);
        check(v == 8'h00, "R1 data after reset", v, 0);
        check(irq_o == 1'b0, "R1 irq after reset", irq_o, 0);
        check(stall_o == 1'b0, "R1 stall after reset", stall_o, 0);

        // table walk: R2 location readback, R6 program, R3 fetch
        foreach (VECS[i]) begin
            prog_byte(VECS[i].addr_byte, VECS[i].data, 8'h00);
            wait_idle();
            bus_write(2'd0, VECS[i].addr_byte);
            peek(2'd0, v);
            check(v == {2'b00, VECS[i].exp_addr}, "R2 location readback", v, {2'b00, VECS[i].exp_addr});
            fetch_byte(VECS[i].addr_byte, v);
            check(v == VECS[i].data, "R6 stored byte", v, VECS[i].data);
        end
        // R2 distinct locations: 63 and 0 kept their values
        fetch_byte(8'h3F, v);
        check(v == 8'h5A, "R2 location 63 kept", v, 8'h5A);
        fetch_byte(8'h00, v);
        check(v == 8'hA5, "R2 location 0 kept", v, 8'hA5);

        // R5 arm window: four cycles set, then cleared by hardware
        bus_write(2'd2, 8'h04);
        for (int i = 0; i < 5; i++) begin
            peek(2'd2, c);
            check(c[2] == (i < 4), "R5 arm window", int'(c[2]), int'(i < 4));
            if (i == 1) bus_write(2'd2, 8'h00);
            else step();
        end

        // R5 request in the first cycle after expiry is rejected
        bus_write(2'd2, 8'h04);
        repeat (4) step();
        bus_write(2'd2, 8'h02);
        peek(2'd2, c);
        check(c[1] == 1'b0, "R5 late request rejected", int'(c[1]), 0);
        check(stall_o == 1'b0, "R8 no stall on reject", stall_o, 0);

        // R4 arm and program in one write is rejected
        bus_write(2'd0, 8'h05);
        bus_write(2'd1, 8'hEE);
        bus_write(2'd2, 8'h06);
        peek(2'd2, c);
        check(c[1] == 1'b0, "R4 single write rejected", int'(c[1]), 0);
        check(c[2] == 1'b1, "R4 arm set by single write", int'(c[2]), 1);
        repeat (5) step();
        // R4 program without arm rejected
        bus_write(2'd2, 8'h02);
        peek(2'd2, c);
        check(c[1] == 1'b0, "R4 unarmed request rejected", int'(c[1]), 0);

        // R5 last armed cycle accepted; R6 length; R8 stall
        bus_write(2'd0, 8'h09);
        bus_write(2'd1, 8'h6B);
        bus_write(2'd2, 8'h04);
        repeat (3) step();
        bus_write(2'd2, 8'h02);
        peek(2'd2, c);
        check(c[2] == 1'b0, "R5 arm consumed", int'(c[2]), 0);
        n = 0;
        while (c[1] && n < 4 * PROG) begin
            if (n < 2) check(stall_o == 1'b1, "R8 stall during access", stall_o, 1);
            else if (n == 2) check(stall_o == 1'b0, "R8 stall ended", stall_o, 0);
            n++;
            step();
            peek(2'd2, c);
        end
        check(n == PROG, "R6 programming length", n, PROG);
        fetch_byte(8'h09, v);
        check(v == 8'h6B, "R5 accepted in last armed cycle", v, 8'h6B);

        // R9/R10 requests and register writes during programming
        prog_byte(8'h0B, 8'h22, 8'h00);
        wait_idle();
        prog_byte(8'h0A, 8'h77, 8'h00);
        repeat (2) step();
        bus_write(2'd2, 8'h01);
        peek(2'd2, c);
        check(c[0] == 1'b0, "R9 fetch ignored while busy", int'(c[0]), 0);
        check(stall_o == 1'b0, "R9 no stall for ignored fetch", stall_o, 0);
        bus_write(2'd0, 8'h0B);
        bus_write(2'd1, 8'h11);
        peek(2'd1, v);
        check(v == 8'h11, "R9 data untouched by ignored fetch", v, 8'h11);
        wait_idle();
        fetch_byte(8'h0A, v);
        check(v == 8'h77, "R10 programmed value intact", v, 8'h77);
        fetch_byte(8'h0B, v);
        check(v == 8'h22, "R10 other location intact", v, 8'h22);

        // R7 level interrupt
        bus_write(2'd2, 8'h08);
        #1;
        check(irq_o == 1'b1, "R7 irq idle enabled", irq_o, 1);
        step();
        #1;
        check(irq_o == 1'b1, "R7 irq stays high", irq_o, 1);
        gie_i = 1'b0;
        #1;
        check(irq_o == 1'b0, "R7 irq masked by gie", irq_o, 0);
        gie_i = 1'b1;
        prog_byte(8'h30, 8'h5C, 8'h08);
        #1;
        check(irq_o == 1'b0, "R7 irq low while busy", irq_o, 0);
        wait_idle();
        #1;
        check(irq_o == 1'b1, "R7 irq back when done", irq_o, 1);
        bus_write(2'd2, 8'h00);
        #1;
        check(irq_o == 1'b0, "R7 irq off when disabled", irq_o, 0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule